// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control front end of a six-bit step attenuator. It turns a set of slow, asynchronous board-level control pins into one registered attenuation word in half-decibel units, held in a free-running system clock domain. A mode pin picks who drives the word. In parallel mode, six code pins drive the word, either through the latch or straight through. In serial mode, a three-wire port (bit clock, bit data, latch enable) fills a six-bit shift register.

One transparent hold stage serves both modes. While latch enable is high, the output tracks the selected source. While it is low, the last value is kept. Leaving synchronous reset puts a defined power-up word on the output. That word comes from the parallel code pins, or from one of four presets picked by two select pins, depending on the mode pin and the latch-enable level during reset. Every input passes through a two-flop synchronizer. Serial clock edges are found by sampling, so the system clock must run at least four times faster than the serial clock.

Top module: `step_atten_ctrl`

## Requirements
- R1: `mode_ser_i` = 0 selects the parallel code pins as the source, and 1 selects the serial shift register.
- R2: `atten_code_o` is an unsigned code N meaning N × 0.5 dB. Bit 5 weighs 16 dB, bit 4 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB, so the range is 0 to 63 (31.5 dB).
- R3: In serial mode, each rising edge of `sclk_i` shifts `sdata_i` into the six-bit register from the bottom. The first bit sent lands in bit 5 (16 dB) and the sixth lands in bit 0 (0.5 dB).
- R4: Shifting takes place whatever the level of `latch_en_i`. A word shifted in while latch enable is low leaves the output unchanged until latch enable goes high.
- R5: While the synchronized latch enable is low, `atten_code_o` holds its value.
- R6: In parallel mode with latch enable high, `atten_code_o` follows `par_code_i` directly.
- R7: In parallel mode, `sclk_i` and `sdata_i` have no effect on the output or on the serial register.
- R8: When reset is released with `mode_ser_i` = 1, the output word equals `par_code_i`.
- R9: When reset is released with `mode_ser_i` = 0 and latch enable low, `preset_sel_i` (bit 1 is the MSB) gives 00 → code 0, 01 → code 16 (8 dB), 10 → code 32 (16 dB), 11 → code 63 (31.5 dB).
- R10: When reset is released with `mode_ser_i` = 0 and latch enable high, `preset_sel_i` is ignored and the output equals `par_code_i`.
- R11: A change on a control pin reaches `atten_code_o` on the third rising system clock edge after the change. A serial clock rising edge updates the serial register on the third edge after it, and the output on the fourth edge.
- R12: The power-up word stays in place until latch enable is high (in serial mode, the serial register is preloaded with the same word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, free running |
| rst | input | 1 | Synchronous active-high reset; power-up word loaded while high |
| mode_ser_i | input | 1 | Source select: 0 parallel, 1 serial (asynchronous) |
| latch_en_i | input | 1 | Latch enable: high transparent, low hold (asynchronous) |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial bit data, MSB first (asynchronous) |
| preset_sel_i | input | 2 | Power-up preset select for parallel mode with latch enable low |
| par_code_i | input | 6 | Parallel attenuation code (asynchronous) |
| atten_code_o | output | 6 | Registered attenuation code, N × 0.5 dB |

## Verification
A pin driven between clock edges shows at the output on the third rising edge that follows. A serial clock rise reaches the output one edge later, because the edge must first pass through the shift register. The reference model keeps a queue of pin samples and reads the entry from two edges back, so its view matches the synchronized view. It compares with the output at every falling edge. The directed latency checks sample the output at the second falling edge after a change, where the old value is expected, and at the third, where the new value is expected. Power-up checks are made a few cycles after reset release, once the output has had time to settle.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

    // Width of the attenuation word (LSB = 0.5 dB).
    localparam int ATTEN_W = 6;
    localparam int PSEL_W  = 2;

    typedef logic [ATTEN_W-1:0] atten_code_t;

    // Which source feeds the hold stage.
    typedef enum logic {
        SRC_PARALLEL = 1'b0,
        SRC_SERIAL   = 1'b1
    } src_sel_e;

    // All control pins carried together through the synchronizer.
    typedef struct packed {
        logic                mode_ser;
        logic                latch_en;
        logic                sclk;
        logic                sdata;
        logic [PSEL_W-1:0]   psel;
        atten_code_t         code;
    } pin_bundle_t;

    localparam int BUNDLE_W = $bits(pin_bundle_t);

    // Preset words: zero, half scale / 2, half scale, full scale.
    function automatic atten_code_t preset_word(input logic [PSEL_W-1:0] sel);
        atten_code_t w;
        case (sel)
            2'b00:   w = '0;
            2'b01:   w = atten_code_t'(1) << (ATTEN_W - 2);
            2'b10:   w = atten_code_t'(1) << (ATTEN_W - 1);
            default: w = '1;
        endcase
        return w;
    endfunction

    // Word placed on the output when reset is released.
    function automatic atten_code_t powerup_word(input pin_bundle_t p);
        atten_code_t w;
        if (p.mode_ser || p.latch_en) begin
            w = p.code;
        end else begin
            w = preset_word(p.psel);
        end
        return w;
    endfunction

    function automatic src_sel_e mode_to_src(input logic mode_ser);
        return mode_ser ? SRC_SERIAL : SRC_PARALLEL;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    // No reset: the chain keeps sampling during reset so the power-up
    // decision sees the pin levels.
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
    import atten_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  src_sel_e    src_i,
    input  logic        sclk_i,
    input  logic        sdata_i,
    input  atten_code_t preload_i,
    output atten_code_t shreg_o
);
    logic sclk_prev;
    logic sclk_rise;

    always_ff @(posedge clk) begin
        sclk_prev <= sclk_i;
    end

    assign sclk_rise = sclk_i & ~sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_o <= preload_i;
        end else if (src_i == SRC_SERIAL && sclk_rise) begin
            shreg_o <= {shreg_o[ATTEN_W-2:0], sdata_i};
        end
    end

    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (src_i == SRC_SERIAL && sclk_rise) |=>
            (shreg_o[0] == $past(sdata_i)) &&
            (shreg_o[ATTEN_W-1:1] == $past(shreg_o[ATTEN_W-2:0]))); // R3

    AST_PAR_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (src_i == SRC_PARALLEL) |=> $stable(shreg_o)); // R7

endmodule

// File: rtl/code_latch.sv
module code_latch
    import atten_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        le_i,
    input  src_sel_e    src_i,
    input  atten_code_t par_code_i,
    input  atten_code_t shreg_i,
    input  atten_code_t pwr_word_i,
    output atten_code_t code_o
);
    atten_code_t src_word;

    always_comb begin
        unique case (src_i)
            SRC_SERIAL:   src_word = shreg_i;
            default:      src_word = par_code_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= pwr_word_i;
        end else if (le_i) begin
            code_o <= src_word;
        end
    end

    AST_LE_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !le_i |=> $stable(code_o)); // R5

    AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (le_i && src_i == SRC_PARALLEL) |=> (code_o == $past(par_code_i))); // R6

    AST_SER_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (le_i && src_i == SRC_SERIAL) |=> (code_o == $past(shreg_i))); // R4

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import atten_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_ser_i,
    input  logic               latch_en_i,
    input  logic               sclk_i,
    input  logic               sdata_i,
    input  logic [PSEL_W-1:0]  preset_sel_i,
    input  logic [ATTEN_W-1:0] par_code_i,
    output logic [ATTEN_W-1:0] atten_code_o
);
    pin_bundle_t          raw_pins;
    pin_bundle_t          syn_pins;
    logic [BUNDLE_W-1:0]  syn_vec;
    atten_code_t          pwr_word;
    atten_code_t          shreg;
    atten_code_t          code_q;
    src_sel_e             src_sel;

    assign raw_pins = '{mode_ser: mode_ser_i, latch_en: latch_en_i,
                        sclk: sclk_i, sdata: sdata_i,
                        psel: preset_sel_i, code: par_code_i};

    pin_sync #(.WIDTH(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (raw_pins),
        .q_o (syn_vec)
    );

    assign syn_pins = pin_bundle_t'(syn_vec);
    assign pwr_word = powerup_word(syn_pins);
    assign src_sel  = mode_to_src(syn_pins.mode_ser);

    serial_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_sel),
        .sclk_i    (syn_pins.sclk),
        .sdata_i   (syn_pins.sdata),
        .preload_i (pwr_word),
        .shreg_o   (shreg)
    );

    code_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .le_i       (syn_pins.latch_en),
        .src_i      (src_sel),
        .par_code_i (syn_pins.code),
        .shreg_i    (shreg),
        .pwr_word_i (pwr_word),
        .code_o     (code_q)
    );

    assign atten_code_o = code_q;

    AST_PWRUP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !$past(syn_pins.mode_ser) && !$past(syn_pins.latch_en)
         && $past(syn_pins.psel) == 2'b00) |-> (atten_code_o == '0)); // R9

    AST_PWRUP_FULL: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !$past(syn_pins.mode_ser) && !$past(syn_pins.latch_en)
         && $past(syn_pins.psel) == 2'b11) |-> (atten_code_o == '1)); // R9

    AST_PWRUP_SERIAL: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && $past(syn_pins.mode_ser)) |->
            (atten_code_o == $past(syn_pins.code))); // R8

endmodule

// File: tb/tb_step_atten_ctrl.sv
module tb_step_atten_ctrl;
    import atten_ctrl_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_ser = 1'b0;
    logic       le = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [1:0] psel = 2'b00;
    logic [5:0] par = 6'd0;
    logic [5:0] out;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R11";
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_atten_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .mode_ser_i   (mode_ser),
        .latch_en_i   (le),
        .sclk_i       (sclk),
        .sdata_i      (sdata),
        .preset_sel_i (psel),
        .par_code_i   (par),
        .atten_code_o (out)
    );

    // ---------------- behavioural reference model ----------------
    pin_bundle_t hist[$];
    int  m_out = 0;
    int  m_ser = 0;
    bit  m_live = 1'b0;

    always @(posedge clk) begin
        pin_bundle_t v;
        pin_bundle_t pv;
        int nxt_ser;
        if (hist.size() >= 3) begin
            v  = hist[hist.size()-2];
            pv = hist[hist.size()-3];
            if (rst) begin
                if (v.mode_ser || v.latch_en) m_out = int'(v.code);
                else begin
                    case (v.psel)
                        2'b00: m_out = 0;
                        2'b01: m_out = 16;
                        2'b10: m_out = 32;
                        default: m_out = 63;
                    endcase
                end
                m_ser = m_out;
            end else begin
                nxt_ser = m_ser;
                if (v.mode_ser && v.sclk && !pv.sclk)
                    nxt_ser = ((m_ser * 2) % 64) + int'(v.sdata);
                if (v.latch_en) m_out = v.mode_ser ? m_ser : int'(v.code);
                m_ser = nxt_ser;
                m_live = 1'b1;
            end
        end
        hist.push_back('{mode_ser: mode_ser, latch_en: le, sclk: sclk,
                         sdata: sdata, psel: psel, code: par});
        if (hist.size() > 5) void'(hist.pop_front());
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: atten_code_o=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_live && !rst && !done) check({cur_req, " (model)"}, int'(out), m_out);
    end

    // ---------------- stimulus helpers ----------------
    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cycles(5);
        rst = 1'b0;
        cycles(4);
    endtask

    task automatic send_serial(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) begin
            sdata = w[i];
            cycles(4);
            sclk = 1'b1;
            cycles(4);
            sclk = 1'b0;
        end
        cycles(6);
    endtask

    task automatic pulse_le();
        le = 1'b1;
        cycles(4);
        le = 1'b0;
        cycles(5);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        // R9 / R2: parallel, LE low, presets
        cur_req = "R9";
        mode_ser = 1'b0; le = 1'b0; par = 6'd5;
        psel = 2'b01; do_reset(); check("R9 preset 01 (R2 8 dB)", int'(out), 16);
        psel = 2'b10; do_reset(); check("R9 preset 10 (R2 16 dB)", int'(out), 32);
        psel = 2'b11; do_reset(); check("R9 preset 11 (R2 31.5 dB)", int'(out), 63);
        psel = 2'b00; par = 6'd44; do_reset(); check("R9 preset 00", int'(out), 0);

        // R12 / R5: power-up word held while LE low
        cur_req = "R12";
        par = 6'd27; cycles(6);
        check("R12 power-up held with LE low", int'(out), 0);

        // R10: parallel, LE high at reset, preset ignored
        cur_req = "R10";
        psel = 2'b11; le = 1'b1; par = 6'd37; do_reset();
        check("R10 power-up follows code", int'(out), 37);

        // R6 / R11: direct mode latency
        cur_req = "R6";
        par = 6'd12;
        cycles(2); check("R11 old value two edges after change", int'(out), 37);
        cycles(1); check("R11 new value on third edge", int'(out), 12);
        check("R6 direct follow", int'(out), 12);

        // R7: serial pins ignored in parallel mode
        cur_req = "R7";
        send_serial(6'b111111);
        check("R7 serial ignored in parallel mode", int'(out), 12);

        // R5: latched parallel
        cur_req = "R5";
        le = 1'b0; cycles(3); par = 6'd50; cycles(5);
        check("R5 hold while LE low", int'(out), 12);
        pulse_le();
        check("R5 latched new code", int'(out), 50);
        par = 6'd7; cycles(5);
        check("R5 hold after LE falls", int'(out), 50);

        // R8: serial power-up from parallel pins
        cur_req = "R8";
        mode_ser = 1'b1; psel = 2'b10; par = 6'd21; le = 1'b0; do_reset();
        check("R8 serial power-up word", int'(out), 21);

        // R4 / R3: shift with LE low, then latch
        cur_req = "R4";
        send_serial(6'b101101);
        check("R4 shift with LE low leaves output", int'(out), 21);
        pulse_le();
        check("R3 MSB-first word latched", int'(out), 45);

        // R3: transparent serial, serial-clock latency (R11)
        cur_req = "R3";
        le = 1'b1; cycles(4);
        check("R12 transparent shows latched register", int'(out), 45);
        sdata = 1'b0; cycles(4);
        sclk = 1'b1;
        cycles(3); check("R11 serial old value three edges after clock", int'(out), 45);
        cycles(1); check("R11 serial new value on fourth edge", int'(out), 26);
        sclk = 1'b0; cycles(4);
        send_serial(6'b000011);
        check("R3 transparent serial word", int'(out), 3);

        // R1: switch back to parallel source
        cur_req = "R1";
        par = 6'd9; mode_ser = 1'b0; cycles(5);
        check("R1 mode 0 selects parallel", int'(out), 9);
        mode_ser = 1'b1; cycles(5);
        check("R1 mode 1 selects serial register", int'(out), 3);
        cycles(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule